// File: doc/BRIEF.md
# Configurable LUT Logic Element

This block is the programmable cell of a small island-style fabric. A two-input lookup table computes any Boolean function of its inputs from four configuration bits. A 4-to-1 multiplexer steered by the two logic inputs picks one of those bits. The table result can go straight to the output, or it can first pass through a D flip-flop. A pair of configuration bits can force that flip-flop to one or to zero, in place of dedicated preset and clear pins.

Configuration is loaded over a parallel port. While `prog_en` is high, the configuration register takes `cfg_data` on every rising clock edge and the flip-flop is held cleared. When `prog_en` is low, the stored configuration stays fixed and the element does its logic function. The table is indexed with a reversed select order. Input value 3 reads truth-table bit 0 and input value 0 reads truth-table bit 3.

Top module: `cle_logic_element`

## Requirements
- R1: A synchronous active-high `rst` clears the configuration register and the flip-flop. The output then reads 0 for every `lut_in` value.
- R2: When `prog_en` is high at a rising edge, the configuration register takes `cfg_data`. When `prog_en` is low, `cfg_data` has no effect on the stored configuration.
- R3: Configuration bits [3:0] form the truth table. With v = {lut_in[1], lut_in[0]}, the table result is cfg[3 - v]: inputs 11 read bit 0, 10 read bit 1, 01 read bit 2 and 00 read bit 3.
- R4: Configuration bit 6 selects the output path. A value of 0 drives `le_out` combinationally from the table result. A value of 1 drives it from the flip-flop.
- R5: When configuration bits [5:4] are 11 and `prog_en` is low, the flip-flop becomes 1 at the next edge, whatever the table result is.
- R6: When configuration bits [5:4] are 00, the flip-flop becomes 0 at the next edge, whatever the table result is.
- R7: When configuration bits [5:4] are 01 or 10 and `prog_en` is low, the flip-flop captures the table result at each rising edge.
- R8: While `prog_en` is high, the flip-flop is held at 0. A newly written configuration controls the output starting from the edge that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | Program mode: loads the configuration and holds the flip-flop cleared |
| cfg_data | input | 7 | Parallel configuration word (truth table, set/reset pair, output select) |
| lut_in | input | 2 | Logic inputs that index the lookup table |
| le_out | output | 1 | Element output, combinational or registered |

## Verification
The flip-flop assertions assume that the set and clear controls from the decoder are never active together. They also assume that the table input to the flip-flop has settled before each rising edge. The bench meets both conditions. It changes `lut_in`, `prog_en` and `cfg_data` only on falling edges. It sweeps all 128 configuration words through the normal programming sequence, and each word is followed by all four input values in an order that varies from word to word. During run phases, the bench drives the complement of the programmed word onto `cfg_data`. Any leak from that port into the stored configuration would then change the observed output.

// File: rtl/cle_pkg.sv
package cle_pkg;

    localparam int unsigned CLE_K = 2;

    typedef enum logic [1:0] {
        SR_CLEAR  = 2'b00,
        SR_PASS_A = 2'b01,
        SR_PASS_B = 2'b10,
        SR_SET    = 2'b11
    } sr_mode_e;

    typedef struct packed {
        logic set;
        logic clr;
    } ff_ctrl_t;

    function automatic int unsigned lut_size(input int unsigned k);
        return 32'd1 << k;
    endfunction

    function automatic int unsigned cfg_width(input int unsigned k);
        return lut_size(k) + 3;
    endfunction

    function automatic ff_ctrl_t decode_sr(input sr_mode_e mode, input logic prog);
        ff_ctrl_t c;
        c.set = (mode == SR_SET) && !prog;
        c.clr = (mode == SR_CLEAR) || prog;
        return c;
    endfunction

endpackage

// File: rtl/cle_cfg_reg.sv
module cle_cfg_reg #(
    parameter int unsigned CFG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_en_i,
    input  logic [CFG_W-1:0] cfg_d_i,
    output logic [CFG_W-1:0] cfg_q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q_o <= '0;
        end else if (prog_en_i) begin
            cfg_q_o <= cfg_d_i;
        end
    end

    // R2: a word presented in program mode is held after the edge
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        prog_en_i |=> (cfg_q_o == $past(cfg_d_i)));

    // R2: outside program mode the stored word does not move
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !prog_en_i |=> $stable(cfg_q_o));

endmodule

// File: rtl/cle_lut.sv
module cle_lut #(
    parameter int unsigned K = 2
) (
    input  logic [(1<<K)-1:0] tt_i,
    input  logic [K-1:0]      sel_i,
    output logic              y_o
);

    localparam int unsigned N = 1 << K;

    logic [N-1:0] rev;

    // reversed select order: select value v reads truth bit N-1-v
    for (genvar i = 0; i < N; i++) begin : g_rev
        assign rev[i] = tt_i[N-1-i];
    end

    assign y_o = rev[sel_i];

endmodule

// File: rtl/cle_sr_decode.sv
module cle_sr_decode
    import cle_pkg::*;
(
    input  logic [1:0] sr_bits_i,
    input  logic       prog_en_i,
    output ff_ctrl_t   ctrl_o
);

    sr_mode_e mode;

    assign mode   = sr_mode_e'(sr_bits_i);
    assign ctrl_o = decode_sr(mode, prog_en_i);

endmodule

// File: rtl/cle_dff.sv
module cle_dff (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end else begin
            q_o <= d_i;
        end
    end

    // R5: set and clear from the decoder are never active together
    a_r5_sr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(set_i && clr_i));

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !q_o);

    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> (q_o == $past(d_i)));

endmodule

// File: rtl/cle_logic_element.sv
module cle_logic_element
    import cle_pkg::*;
#(
    parameter int unsigned K = CLE_K
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            prog_en,
    input  logic [cfg_width(K)-1:0]         cfg_data,
    input  logic [K-1:0]                    lut_in,
    output logic                            le_out
);

    localparam int unsigned LUT_N  = lut_size(K);
    localparam int unsigned CFG_W  = cfg_width(K);
    localparam int unsigned SR_LSB = LUT_N;
    localparam int unsigned OSEL   = LUT_N + 2;

    logic [CFG_W-1:0] cfg_q;
    logic             lut_y;
    ff_ctrl_t         ctrl;
    logic             ff_q;

    cle_cfg_reg #(.CFG_W(CFG_W)) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .prog_en_i (prog_en),
        .cfg_d_i   (cfg_data),
        .cfg_q_o   (cfg_q)
    );

    cle_lut #(.K(K)) lut_i (
        .tt_i  (cfg_q[LUT_N-1:0]),
        .sel_i (lut_in),
        .y_o   (lut_y)
    );

    cle_sr_decode sr_i (
        .sr_bits_i (cfg_q[SR_LSB+1:SR_LSB]),
        .prog_en_i (prog_en),
        .ctrl_o    (ctrl)
    );

    cle_dff ff_i (
        .clk   (clk),
        .rst   (rst),
        .set_i (ctrl.set),
        .clr_i (ctrl.clr),
        .d_i   (lut_y),
        .q_o   (ff_q)
    );

    assign le_out = cfg_q[OSEL] ? ff_q : lut_y;

    // R8: program mode leaves the flip-flop cleared
    a_r8_prog_clear: assert property (@(posedge clk) disable iff (rst)
        prog_en |=> !ff_q);

    // R1: one cycle after reset both the register and the flip-flop read zero
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cfg_q == '0 && !ff_q));

endmodule

// File: tb/cle_logic_element_tb.sv
module cle_logic_element_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       prog_en;
    logic [6:0] cfg_data;
    logic [1:0] lut_in;
    logic       le_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    cle_logic_element dut_i (
        .clk      (clk),
        .rst      (rst),
        .prog_en  (prog_en),
        .cfg_data (cfg_data),
        .lut_in   (lut_in),
        .le_out   (le_out)
    );

    function automatic logic table_bit(input logic [6:0] c, input int v);
        return c[3 - v];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: le_out=%b expected %b (cfg=%b lut_in=%b)",
                     tag, act, exp, cfg_data, lut_in);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic qm;
        rst = 1'b1; prog_en = 1'b0; cfg_data = 7'h7f; lut_in = 2'b00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state reads zero for all inputs
        for (int v = 0; v < 4; v++) begin
            lut_in = v[1:0];
            #1 check("R1", le_out, 1'b0);
        end
        rst = 1'b0;

        for (int c = 0; c < 128; c++) begin
            logic [6:0] cw;
            cw = c[6:0];
            @(negedge clk);
            prog_en = 1'b1; cfg_data = cw; lut_in = 2'b00;
            @(posedge clk);
            @(negedge clk);
            // R8: new word in force, flip-flop held clear in program mode
            if (cw[6]) check("R8", le_out, 1'b0);
            else       check("R8 R3", le_out, table_bit(cw, 0));
            prog_en = 1'b0;
            cfg_data = ~cw;   // R2: must be ignored while not programming
            qm = 1'b0;
            for (int s = 0; s < 4; s++) begin
                int v;
                v = (s * 3 + c) % 4;
                lut_in = v[1:0];
                #1;
                if (!cw[6]) check("R3 R4 R2", le_out, table_bit(cw, v));
                @(posedge clk);
                case (cw[5:4])
                    2'b11:   qm = 1'b1;
                    2'b00:   qm = 1'b0;
                    default: qm = table_bit(cw, v);
                endcase
                @(negedge clk);
                if (cw[6]) begin
                    case (cw[5:4])
                        2'b11:   check("R5 R4 R2", le_out, qm);
                        2'b00:   check("R6 R4 R2", le_out, qm);
                        default: check("R7 R4 R2", le_out, qm);
                    endcase
                end
            end
        end

        // R1: reset mid-run clears a registered, set-forced configuration
        @(negedge clk);
        prog_en = 1'b1; cfg_data = 7'b1110000;
        @(negedge clk);
        prog_en = 1'b0;
        @(negedge clk);
        check("R5", le_out, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < 4; v++) begin
            lut_in = v[1:0];
            #1 check("R1", le_out, 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule